// File: doc/BRIEF.md
# Dual configurable FIR filter pair

Two fixed-point FIR networks, A and B, share one sample clock and one control word. Each network owns eight multipliers that are reused over several clock cycles. The number of taps therefore grows with the number of clock cycles available per output. The control word either runs the two networks as separate filters, each with its own 16-bit input and 32-bit result, or chains them. In the chained case network B filters a 16-bit slice of network A's result, which gives better stop-band rejection than one long fixed-point filter.

The block gates sample acceptance to the selected input rate. Separate filters can optionally decimate by two. Coefficients are loaded through a plain write port, and the result bus driven by network A has a registered output enable. Every result is marked by a one-cycle valid pulse. The latency from input acceptance to that pulse is fixed by the configuration.

Top module: `dual_fir`

## Requirements
- R1: When ctrl_i[15] is 1, both networks are idle and neither f_valid_o nor x_valid_o pulses.
- R2: ctrl_i[14:13] = 0,1,2,3 gives K = 1,2,4,8 clock cycles per input sample. Counting the edge that loads a new control word as edge 0, inputs are sampled on edges 1+nK, and values present on any other edge have no effect.
- R3: With ctrl_i[4]=0 and ctrl_i[12]=0, output n of A is the sum of cA[k]*da(n-k) over k < 8K. B computes the same over k < 8K using db and cB. Samples before the first accepted one count as zero.
- R4: With ctrl_i[4]=0 and ctrl_i[12]=1, a result is produced only on the 2nd, 4th, 6th... accepted sample and spans 16K taps. Rate code 3 together with decimation is invalid and leaves the block idle.
- R5: With ctrl_i[4]=1, B's input is bits 23:8 of A's result and B's result is the X output. f_valid_o never pulses, and ctrl_i[12] has no effect.
- R6: The valid pulse follows the edge that accepts the sample by 16, 16, 20, 24 cycles for separate filters without decimation (rate codes 0..3). With decimation the delays are 17, 18, 24 for rate codes 0..2. In cascade the delays are 27, 28, 36, 40.
- R7: Products are summed in groups of eight taps (taps 8g..8g+7). The running sum is clamped to the signed 32-bit range after each group is added.
- R8: oe_i is registered on the clock edge. While the registered value is 0, f_o reads zero.
- R9: Any change of ctrl_i restarts the phase and pair counters and clears sample history and pending results. No result from the old setting appears after the change.
- R10: A write with coef_we_i=1 stores coef_data_i as the coefficient of tap coef_addr_i (tap 0 multiplies the newest sample) in network A when coef_net_i=0 or in network B when coef_net_i=1.
- R11: After reset, f_o and x_o are zero and both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 16 | Control word |
| da_i | input | 16 | Network A input sample, signed |
| db_i | input | 16 | Network B input sample, signed (separate mode) |
| oe_i | input | 1 | Output enable for f_o, registered |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_net_i | input | 1 | Coefficient target network: 0 is A, 1 is B |
| coef_addr_i | input | 6 | Tap index of the write |
| coef_data_i | input | 16 | Signed coefficient value |
| f_o | output | 32 | Network A result in separate mode |
| f_valid_o | output | 1 | One-cycle pulse for a new f_o result |
| x_o | output | 32 | Network B result, or the chained result |
| x_valid_o | output | 1 | One-cycle pulse for a new x_o result |

## Verification
Every rate code is run in separate, decimating and chained modes. The inputs change every cycle, so a filter that sampled on the wrong edge or used the wrong tap span would produce different sums than the arithmetic model. Different ramps on the two inputs, with different coefficient sets, separate a swapped or shared data path from a correct one. The chained runs use coefficients large enough to make the 23:8 slice significant. A run of full-scale samples of alternating sign with maximum coefficients drives the clamping in both directions. The idle settings, the invalid rate with decimation, and the chained setting with the decimation bit set show whether the control decode stays quiet or ignores that bit. An output-enable pattern toggled during a run shows the one-edge delay of the gate.

// File: rtl/dual_fir_pkg.sv
package dual_fir_pkg;
  localparam int DATA_W   = 16;
  localparam int ACC_W    = 32;
  localparam int MACS     = 8;
  localparam int TAPS_MAX = 64;
  localparam int CAS_LSB  = 8;
  localparam int DLY_D    = 32;
  localparam int DLY_SW   = $clog2(DLY_D);

  typedef struct packed {
    logic       active;
    logic       cascade;
    logic       dec;
    logic [1:0] rate;
  } cfg_t;

  function automatic cfg_t decode_cfg(input logic [15:0] w);
    cfg_t c;
    c.cascade = w[4];
    c.rate    = w[14:13];
    c.dec     = w[12] & ~w[4];
    c.active  = ~w[15] & ~(c.dec & (w[14:13] == 2'd3));
    return c;
  endfunction

  // extra cycles after the MAC pass to reach the fixed latency
  function automatic logic [DLY_SW-1:0] pad_sep(input cfg_t c);
    case (c.rate)
      2'd0:    return DLY_SW'(15);
      2'd1:    return DLY_SW'(14);
      default: return DLY_SW'(16);
    endcase
  endfunction

  function automatic logic [DLY_SW-1:0] pad_cas(input cfg_t c);
    case (c.rate)
      2'd0:    return DLY_SW'(24);
      2'd1:    return DLY_SW'(23);
      2'd2:    return DLY_SW'(27);
      default: return DLY_SW'(23);
    endcase
  endfunction
endpackage

// File: rtl/dual_fir_seq.sv
module dual_fir_seq
  import dual_fir_pkg::*;
#(
  parameter int GW = $clog2(TAPS_MAX / MACS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [15:0]   ctrl_i,
  output cfg_t          cfg_o,
  output logic          restart_o,
  output logic          accept_o,
  output logic          start_o,
  output logic [GW-1:0] grp_last_o
);
  logic [15:0] ctrl_q;
  logic [2:0]  phase_q;
  logic        pair_q;
  logic [3:0]  k_cnt;
  logic [4:0]  g_cnt;
  logic [2:0]  k_last;

  always_comb begin
    cfg_o      = decode_cfg(ctrl_q);
    restart_o  = ctrl_i != ctrl_q;
    k_cnt      = 4'd1 << cfg_o.rate;
    k_last     = 3'(k_cnt - 4'd1);
    g_cnt      = 5'(k_cnt) << cfg_o.dec;
    grp_last_o = GW'(g_cnt - 5'd1);
    accept_o   = cfg_o.active && phase_q == 3'd0 && !restart_o;
    start_o    = accept_o && (!cfg_o.dec || pair_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= 16'h8000;
      phase_q <= '0;
      pair_q  <= 1'b0;
    end else if (restart_o) begin
      ctrl_q  <= ctrl_i;
      phase_q <= '0;
      pair_q  <= 1'b0;
    end else if (cfg_o.active) begin
      phase_q <= (phase_q == k_last) ? 3'd0 : phase_q + 3'd1;
      if (accept_o) pair_q <= ~pair_q;
    end
  end
endmodule

// File: rtl/dual_fir_net.sv
module dual_fir_net #(
  parameter int DW   = 16,
  parameter int AW   = 32,
  parameter int TAPS = 64,
  parameter int MACS = 8,
  localparam int GW  = $clog2(TAPS / MACS),
  localparam int MW  = $clog2(MACS),
  localparam int IW  = $clog2(TAPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic                 accept_i,
  input  logic                 start_i,
  input  logic signed [DW-1:0] sample_i,
  input  logic [GW-1:0]        grp_last_i,
  input  logic                 coef_we_i,
  input  logic [IW-1:0]        coef_addr_i,
  input  logic signed [DW-1:0] coef_data_i,
  output logic signed [AW-1:0] res_o,
  output logic                 done_o
);
  localparam int PW = 2 * DW;
  localparam int QW = PW + MW;
  localparam int SW = AW + 4;
  localparam logic signed [SW-1:0] MAXV = SW'({1'b0, {(AW-1){1'b1}}});
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

  logic signed [DW-1:0] hist_q [TAPS-1];
  logic signed [DW-1:0] snap_q [TAPS];
  logic signed [DW-1:0] coef_q [TAPS];
  logic                 busy_q;
  logic [GW-1:0]        step_q;
  logic signed [AW-1:0] acc_q;
  logic signed [QW-1:0] part;
  logic signed [SW-1:0] sum;
  logic signed [AW-1:0] sum_sat;

  // eight products of the current tap group
  always_comb begin
    part = '0;
    for (int i = 0; i < MACS; i++) begin
      logic [IW-1:0]        idx;
      logic signed [PW-1:0] prod;
      idx  = {step_q, MW'(i)};
      prod = snap_q[idx] * coef_q[idx];
      part = part + QW'(prod);
    end
    sum = (step_q == '0 ? SW'(0) : SW'(acc_q)) + SW'(part);
    if (sum > MAXV)      sum_sat = MAXV[AW-1:0];
    else if (sum < MINV) sum_sat = MINV[AW-1:0];
    else                 sum_sat = sum[AW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) begin
        coef_q[i] <= '0;
        snap_q[i] <= '0;
      end
      for (int i = 0; i < TAPS - 1; i++) hist_q[i] <= '0;
      busy_q <= 1'b0;
      step_q <= '0;
      acc_q  <= '0;
      res_o  <= '0;
      done_o <= 1'b0;
    end else begin
      if (coef_we_i) coef_q[coef_addr_i] <= coef_data_i;
      done_o <= 1'b0;
      if (flush_i) begin
        for (int i = 0; i < TAPS - 1; i++) hist_q[i] <= '0;
        busy_q <= 1'b0;
        step_q <= '0;
        acc_q  <= '0;
      end else begin
        if (accept_i) begin
          hist_q[0] <= sample_i;
          for (int i = 1; i < TAPS - 1; i++) hist_q[i] <= hist_q[i-1];
        end
        if (busy_q) begin
          acc_q  <= sum_sat;
          step_q <= step_q + GW'(1);
          if (step_q == grp_last_i) begin
            res_o  <= sum_sat;
            done_o <= 1'b1;
            busy_q <= 1'b0;
          end
        end
        if (start_i) begin
          snap_q[0] <= sample_i;
          for (int i = 1; i < TAPS; i++) snap_q[i] <= hist_q[i-1];
          busy_q <= 1'b1;
          step_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/dual_fir_dly.sv
module dual_fir_dly #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int SW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          vld_i,
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] sel_i,
  output logic          vld_o,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] d_q [DEPTH-1];
  logic         v_q [DEPTH-1];
  logic [W-1:0] td [DEPTH];
  logic         tv [DEPTH];
  logic [SW-1:0] pick;

  always_comb begin
    td[0] = data_i;
    tv[0] = vld_i;
    for (int i = 1; i < DEPTH; i++) begin
      td[i] = d_q[i-1];
      tv[i] = v_q[i-1];
    end
    pick = sel_i - SW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        d_q[i] <= '0;
        v_q[i] <= 1'b0;
      end
      vld_o  <= 1'b0;
      data_o <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < DEPTH - 1; i++) v_q[i] <= 1'b0;
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        d_q[i] <= td[i];
        v_q[i] <= tv[i];
      end
      vld_o <= tv[pick];
      if (tv[pick]) data_o <= td[pick];
    end
  end
endmodule

// File: rtl/dual_fir.sv
module dual_fir
  import dual_fir_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ACC_W,
  parameter int TAPS = TAPS_MAX,
  localparam int IW  = $clog2(TAPS),
  localparam int GW  = $clog2(TAPS / MACS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [15:0]   ctrl_i,
  input  logic [DW-1:0] da_i,
  input  logic [DW-1:0] db_i,
  input  logic          oe_i,
  input  logic          coef_we_i,
  input  logic          coef_net_i,
  input  logic [IW-1:0] coef_addr_i,
  input  logic [DW-1:0] coef_data_i,
  output logic [AW-1:0] f_o,
  output logic          f_valid_o,
  output logic [AW-1:0] x_o,
  output logic          x_valid_o
);
  cfg_t            cfg;
  logic            restart, accept, start;
  logic [GW-1:0]   grp_last;
  logic signed [AW-1:0] a_res, b_res;
  logic            a_done, b_done;
  logic            b_accept, b_start;
  logic [DW-1:0]   b_sample;
  logic [AW-1:0]   f_data;
  logic            oe_q;

  dual_fir_seq #(.GW(GW)) u_seq (
    .clk_i, .rst_ni, .ctrl_i,
    .cfg_o(cfg), .restart_o(restart), .accept_o(accept),
    .start_o(start), .grp_last_o(grp_last)
  );

  always_comb begin
    b_accept = cfg.cascade ? a_done : accept;
    b_start  = cfg.cascade ? a_done : start;
    b_sample = cfg.cascade ? a_res[CAS_LSB +: DW] : db_i;
  end

  dual_fir_net #(.DW(DW), .AW(AW), .TAPS(TAPS), .MACS(MACS)) u_net_a (
    .clk_i, .rst_ni, .flush_i(restart),
    .accept_i(accept), .start_i(start), .sample_i(da_i),
    .grp_last_i(grp_last),
    .coef_we_i(coef_we_i && !coef_net_i), .coef_addr_i, .coef_data_i,
    .res_o(a_res), .done_o(a_done)
  );

  dual_fir_net #(.DW(DW), .AW(AW), .TAPS(TAPS), .MACS(MACS)) u_net_b (
    .clk_i, .rst_ni, .flush_i(restart),
    .accept_i(b_accept), .start_i(b_start), .sample_i(b_sample),
    .grp_last_i(grp_last),
    .coef_we_i(coef_we_i && coef_net_i), .coef_addr_i, .coef_data_i,
    .res_o(b_res), .done_o(b_done)
  );

  dual_fir_dly #(.W(AW), .DEPTH(DLY_D)) u_dly_f (
    .clk_i, .rst_ni, .flush_i(restart),
    .vld_i(a_done && !cfg.cascade), .data_i(a_res), .sel_i(pad_sep(cfg)),
    .vld_o(f_valid_o), .data_o(f_data)
  );

  dual_fir_dly #(.W(AW), .DEPTH(DLY_D)) u_dly_x (
    .clk_i, .rst_ni, .flush_i(restart),
    .vld_i(b_done), .data_i(b_res),
    .sel_i(cfg.cascade ? pad_cas(cfg) : pad_sep(cfg)),
    .vld_o(x_valid_o), .data_o(x_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= oe_i;
  end

  assign f_o = oe_q ? f_data : '0;
endmodule

// File: rtl/dual_fir_chk.sv
module dual_fir_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          oe_i,
  input logic [AW-1:0] f_o,
  input logic          f_valid_o,
  input logic          x_valid_o,
  input logic          active_i,
  input logic          cascade_i,
  input logic [1:0]    rate_i,
  input logic          restart_i
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (!f_valid_o && !x_valid_o));

  assert_valid_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_valid_o && rate_i != 2'd0) |=> !x_valid_o);

  assert_cascade_f_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cascade_i |-> !f_valid_o);

  assert_oe_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> (f_o == '0));

  assert_restart_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!f_valid_o && !x_valid_o));
endmodule

bind dual_fir dual_fir_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .oe_i(oe_i), .f_o(f_o),
  .f_valid_o(f_valid_o), .x_valid_o(x_valid_o),
  .active_i(cfg.active), .cascade_i(cfg.cascade), .rate_i(cfg.rate),
  .restart_i(restart)
);

// File: tb/dual_fir_test.sv
module dual_fir_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ctrl_i = 16'h8000;
  logic [15:0] da_i = '0, db_i = '0;
  logic        oe_i = 1'b1;
  logic        coef_we_i = 1'b0, coef_net_i = 1'b0;
  logic [5:0]  coef_addr_i = '0;
  logic [15:0] coef_data_i = '0;
  logic [31:0] f_o, x_o;
  logic        f_valid_o, x_valid_o;

  always #4 clk_i = ~clk_i;

  dual_fir uut (
    .clk_i, .rst_ni, .ctrl_i, .da_i, .db_i, .oe_i,
    .coef_we_i, .coef_net_i, .coef_addr_i, .coef_data_i,
    .f_o, .f_valid_o, .x_o, .x_valid_o
  );

  int     checks = 0, errors = 0;
  bit     finished = 0;
  int     ca [64], cb [64];
  longint xs_a [256], xs_b [256];
  int     kk, cg, lf, lx, smode;
  bit     act, casc, dcm;
  string  tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint av, input longint ev);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, av, ev);
    end
  endtask

  function automatic int fsamp(input int sm, input int net, input int e);
    if (sm == 1 && net == 0) return ((e / 20) % 2 == 1) ? 32767 : -32768;
    if (net == 0) return ((e * 73 + 11) % 251) - 125;
    return ((e * 59 + 3) % 233) - 116;
  endfunction

  function automatic bit oe_fn(input int e);
    return ((e / 7) % 4) != 0;
  endfunction

  // R7: group-wise clamped accumulation
  function automatic logic signed [31:0] fir(input int net, input int n);
    longint acc = 0;
    for (int g = 0; g < cg; g++) begin
      longint part = 0;
      for (int i = 0; i < 8; i++) begin
        int k = 8 * g + i;
        longint xv = 0;
        if (n - k >= 0) xv = (net == 1) ? xs_b[n-k] : xs_a[n-k];
        part += xv * ((net == 1) ? cb[k] : ca[k]);
      end
      acc += part;
      if (acc > 64'sd2147483647)  acc = 64'sd2147483647;
      if (acc < -64'sd2147483648) acc = -64'sd2147483648;
    end
    return 32'(acc);
  endfunction

  task automatic write_coef(input bit net, input int a, input int v);
    coef_we_i = 1'b1; coef_net_i = net;
    coef_addr_i = 6'(a); coef_data_i = 16'(v);
    @(negedge clk_i);
    coef_we_i = 1'b0;
  endtask

  task automatic check_edge(input int e);
    int nf = e - 1 - lf;
    int nx = e - 1 - lx;
    bit ef, ex;
    ef = act && !casc && nf >= 0 && nf % kk == 0 && (!dcm || (nf / kk) % 2 == 1);
    ex = act && nx >= 0 && nx % kk == 0 && (!dcm || (nx / kk) % 2 == 1);
    chk(f_valid_o == ef, {tag, "/R6/R9"}, $sformatf("f_valid edge %0d", e), f_valid_o, ef);
    chk(x_valid_o == ex, {tag, "/R6/R9"}, $sformatf("x_valid edge %0d", e), x_valid_o, ex);
    if (!oe_fn(e)) chk(f_o == '0, "R8", "f_o while disabled", f_o, 0);
    else if (ef && f_valid_o) begin
      logic signed [31:0] exp_f = fir(0, nf / kk);
      chk(f_o === exp_f, {tag, "/R10"}, "f_o value", $signed(f_o), exp_f);
    end
    if (ex && x_valid_o) begin
      logic signed [31:0] exp_x = fir(1, nx / kk);
      chk(x_o === exp_x, {tag, "/R10"}, "x_o value", $signed(x_o), exp_x);
    end
  endtask

  task automatic run_cfg(input logic [15:0] w, input int sm);
    int rate = int'(w[14:13]);
    int e_end;
    casc = w[4];
    dcm  = w[12] && !casc;
    act  = !w[15] && !(dcm && rate == 3);
    kk   = 1 << rate;
    cg   = kk * (dcm ? 2 : 1);
    smode = sm;
    case (rate)
      0: begin lf = dcm ? 17 : 16; lx = casc ? 27 : lf; end
      1: begin lf = dcm ? 18 : 16; lx = casc ? 28 : lf; end
      2: begin lf = dcm ? 24 : 20; lx = casc ? 36 : lf; end
      default: begin lf = 24; lx = casc ? 40 : lf; end
    endcase
    tag = !act ? "R1" : casc ? "R5" : dcm ? "R4" : (sm == 1) ? "R7" : "R3";
    // R2: inputs change every cycle; only edges 1+nK may be seen
    for (int n = 0; n < 256; n++) begin
      xs_a[n] = fsamp(sm, 0, 1 + n * kk);
      xs_b[n] = fsamp(sm, 1, 1 + n * kk);
    end
    if (casc)
      for (int n = 0; n < 256; n++) begin
        logic signed [31:0] ya = fir(0, n);
        xs_b[n] = longint'($signed(ya[23:8]));
      end
    e_end = 60 + 80 * kk;
    for (int e = 0; e <= e_end; e++) begin
      if (e == 0) ctrl_i = w;
      da_i = 16'(fsamp(sm, 0, e));
      db_i = 16'(fsamp(sm, 1, e));
      oe_i = oe_fn(e);
      @(negedge clk_i);
      check_edge(e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) begin
      ca[k] = 200 + ((k * 7) % 41);
      cb[k] = ((k * 13) % 29) - 14;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11
    chk(f_o == '0, "R11", "f_o after reset", f_o, 0);
    chk(x_o == '0, "R11", "x_o after reset", x_o, 0);
    chk(!f_valid_o && !x_valid_o, "R11", "valids after reset",
        {f_valid_o, x_valid_o}, 0);
    // R10: coefficients per network, tap-indexed
    for (int k = 0; k < 64; k++) begin
      write_coef(1'b0, k, ca[k]);
      write_coef(1'b1, k, cb[k]);
    end
    run_cfg(16'hA010, 0);
    for (int r = 0; r < 4; r++) run_cfg(16'(r << 13), 0);
    for (int r = 0; r < 3; r++) run_cfg(16'((r << 13) | 16'h1000), 0);
    run_cfg(16'h7000, 0);
    for (int r = 0; r < 4; r++) run_cfg(16'((r << 13) | 16'h0010), 0);
    run_cfg(16'h3010, 0);
    for (int k = 0; k < 64; k++) begin
      ca[k] = 32767;
      write_coef(1'b0, k, ca[k]);
    end
    run_cfg(16'h0000, 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule